// File: doc/BRIEF.md
# Card Event Interrupt Controller

This block drives an active-low interrupt line for a smart-card reader front end. It watches two digital flags from neighbouring logic: a card-presence flag and an overload flag from the card supply's fault sensing. A change in card presence, in either direction, pulls the line low. A rising overload also pulls it low and forces the programmed card supply level to zero. A card extraction also sends a one-cycle power-down request to the supply logic.

The host acknowledges an event through the decoded output of a byte-wide serial command port. The port supplies a chip-select (active low), an address-match flag, a command byte and a valid strobe. An interrupt is raised whatever the state of chip-select or addressing. It can only be cleared by an accepted command, and that command also programs the two-bit supply level. The level written must suit the most recent event:
- A nonzero level acknowledges an insertion.
- A zero level acknowledges an extraction or an overload.

The block keeps sticky cause bits in a status byte, so a host sharing one bus between several readers can poll each device to find the source.

Top module: `card_irq_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, `irq_n_o` is 1, `status_o` is 8'h00, `supply_o` is 0 and `pwr_down_req_o` is 0.
- R2: A change of `card_det_i` takes effect after SYNC_STAGES synchronizer flops plus one edge register. A 0-to-1 change (insertion) and a 1-to-0 change (extraction) each drive `irq_n_o` low on the (SYNC_STAGES+1)-th rising edge after the change. On that edge the matching cause bit is set: insertion is `status_o[0]` and extraction is `status_o[1]`.
- R3: A 0-to-1 change of `ovl_i`, with the same latency, drives `irq_n_o` low, sets `status_o[2]` and forces `supply_o` to 0.
- R4: Raising the interrupt does not depend on `cs_n_i`, `addr_hit_i` or `cmd_valid_i`.
- R5: A command is accepted only when `cmd_valid_i` is 1, `cs_n_i` is 0, `addr_hit_i` is 1, and `cmd_byte_i[7:5]` is 0xx or 101. On the next edge, an accepted command loads `cmd_byte_i[1:0]` into `supply_o`.
- R6: An accepted command clears a pending interrupt, and all cause bits, on the next edge, but only if its level suits the latest event. The latest event is insertion: the level must be nonzero. The latest event is extraction or overload: the level must be zero. Otherwise `irq_n_o` stays low.
- R7: An extraction sets `pwr_down_req_o` for exactly one cycle, on the same edge that lowers `irq_n_o`, and forces `supply_o` to 0.
- R8: If the card is removed and reinserted before an acknowledge, `irq_n_o` stays low in every cycle. Both cause bits are set, and the latest event becomes insertion.
- R9: A command with `cs_n_i` high, `addr_hit_i` low, or opcode bits 110/111 changes neither `irq_n_o`, `status_o` nor `supply_o`.
- R10: `status_o` is laid out as follows: [7] is the pending interrupt, [6:5] are 0, [4:3] are the supply level, and [2:0] are the overload/extraction/insertion cause bits.
- R11: A new event and an accepted, matching clear in the same cycle leave `irq_n_o` low. The cause bits keep their old value ORed with the new one.
- R12: When an overload and a card-detect change arrive in the same cycle, the latest event is recorded as overload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| card_det_i | input | 1 | Asynchronous card-presence flag, 1 = card present |
| ovl_i | input | 1 | Asynchronous supply overload flag |
| cs_n_i | input | 1 | Host chip-select, active low |
| addr_hit_i | input | 1 | Host address matches this device |
| cmd_valid_i | input | 1 | One-cycle strobe marking a received command byte |
| cmd_byte_i | input | 8 | Received command byte |
| irq_n_o | output | 1 | Active-low interrupt |
| supply_o | output | 2 | Programmed card supply level code |
| pwr_down_req_o | output | 1 | One-cycle power-down request on extraction |
| status_o | output | 8 | Readback status byte |

## Verification
The bench builds the block with SYNC_STAGES = 2. At that setting, the three-edge latency from a raw flag change to the interrupt is short enough for a command to be placed exactly in the cycle where an event is detected, which exercises the event-beats-clear rule. The same setting lets a remove-and-reinsert sequence finish well inside an unacknowledged window, so the line can be watched for glitches cycle by cycle.

// File: rtl/card_irq_pkg.sv
package card_irq_pkg;

    localparam int LVL_W  = 2;
    localparam int CMD_W  = 8;
    localparam int OP_W   = 3;
    localparam int CAUSE_W = 3;
    localparam int STAT_W = 8;
    localparam int RSV_W  = STAT_W - 1 - LVL_W - CAUSE_W;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_INS  = 2'd1,
        EV_EXT  = 2'd2,
        EV_OVL  = 2'd3
    } ev_kind_e;

    typedef struct packed {
        logic ovl;
        logic ext;
        logic ins;
    } ev_set_t;

    function automatic logic op_class_ok(input logic [OP_W-1:0] op);
        return (op[OP_W-1] == 1'b0) || (op == 3'b101);
    endfunction

    function automatic ev_kind_e pick_kind(input ev_set_t e);
        if (e.ovl)      return EV_OVL;
        else if (e.ext) return EV_EXT;
        else if (e.ins) return EV_INS;
        else            return EV_NONE;
    endfunction

    function automatic logic ack_fits(input ev_kind_e k, input logic [LVL_W-1:0] lvl);
        if (k == EV_INS) return (lvl != '0);
        else             return (lvl == '0);
    endfunction

endpackage

// File: rtl/card_irq_sync.sv
module card_irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/card_irq_edge.sv
module card_irq_edge
    import card_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    det_s,
    input  logic    ovl_s,
    output ev_set_t ev
);
    logic det_prev;
    logic ovl_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            det_prev <= 1'b0;
            ovl_prev <= 1'b0;
        end else begin
            det_prev <= det_s;
            ovl_prev <= ovl_s;
        end
    end

    always_comb begin
        ev.ins = det_s & ~det_prev;
        ev.ext = ~det_s & det_prev;
        ev.ovl = ovl_s & ~ovl_prev;
    end
endmodule

// File: rtl/card_irq_cmd.sv
module card_irq_cmd
    import card_irq_pkg::*;
(
    input  logic             cs_n,
    input  logic             addr_hit,
    input  logic             valid,
    input  logic [CMD_W-1:0] cmd,
    output logic             acc,
    output logic [LVL_W-1:0] lvl
);
    logic [OP_W-1:0] op;
    logic            unused_mid;

    assign op         = cmd[CMD_W-1 -: OP_W];
    assign unused_mid = ^cmd[CMD_W-OP_W-1:LVL_W];
    assign lvl        = cmd[LVL_W-1:0];
    assign acc        = valid & ~cs_n & addr_hit & op_class_ok(op);
endmodule

// File: rtl/card_irq_core.sv
module card_irq_core
    import card_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ev_set_t           ev,
    input  logic              acc,
    input  logic [LVL_W-1:0]  lvl,
    output logic              irq_n,
    output logic [LVL_W-1:0]  supply,
    output logic              pwr_dn,
    output logic [STAT_W-1:0] status
);
    logic             pend, pend_n;
    ev_set_t          cause, cause_n;
    ev_kind_e         last, last_n;
    logic [LVL_W-1:0] supply_n;
    logic             any_ev;

    assign any_ev = ev.ins | ev.ext | ev.ovl;

    always_comb begin
        pend_n  = pend;
        cause_n = cause;
        last_n  = last;
        if (any_ev) begin
            pend_n  = 1'b1;
            cause_n = cause | ev;
            last_n  = pick_kind(ev);
        end else if (acc && pend && ack_fits(last, lvl)) begin
            pend_n  = 1'b0;
            cause_n = '0;
            last_n  = EV_NONE;
        end

        if (ev.ovl || ev.ext) supply_n = '0;
        else if (acc)         supply_n = lvl;
        else                  supply_n = supply;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= 1'b0;
            cause  <= '0;
            last   <= EV_NONE;
            supply <= '0;
            pwr_dn <= 1'b0;
        end else begin
            pend   <= pend_n;
            cause  <= cause_n;
            last   <= last_n;
            supply <= supply_n;
            pwr_dn <= ev.ext;
        end
    end

    assign irq_n  = ~pend;
    assign status = {pend, {RSV_W{1'b0}}, supply, cause};
endmodule

// File: rtl/card_irq_ctrl.sv
module card_irq_ctrl
    import card_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              card_det_i,
    input  logic              ovl_i,
    input  logic              cs_n_i,
    input  logic              addr_hit_i,
    input  logic              cmd_valid_i,
    input  logic [CMD_W-1:0]  cmd_byte_i,
    output logic              irq_n_o,
    output logic [LVL_W-1:0]  supply_o,
    output logic              pwr_down_req_o,
    output logic [STAT_W-1:0] status_o
);
    logic             det_s;
    logic             ovl_s;
    ev_set_t          ev_w;
    logic             acc_w;
    logic [LVL_W-1:0] lvl_w;

    card_irq_sync #(.STAGES(SYNC_STAGES)) u_sync_det (
        .clk(clk), .rst(rst), .d(card_det_i), .q(det_s)
    );

    card_irq_sync #(.STAGES(SYNC_STAGES)) u_sync_ovl (
        .clk(clk), .rst(rst), .d(ovl_i), .q(ovl_s)
    );

    card_irq_edge u_edge (
        .clk(clk), .rst(rst), .det_s(det_s), .ovl_s(ovl_s), .ev(ev_w)
    );

    card_irq_cmd u_cmd (
        .cs_n(cs_n_i), .addr_hit(addr_hit_i), .valid(cmd_valid_i),
        .cmd(cmd_byte_i), .acc(acc_w), .lvl(lvl_w)
    );

    card_irq_core u_core (
        .clk(clk), .rst(rst), .ev(ev_w), .acc(acc_w), .lvl(lvl_w),
        .irq_n(irq_n_o), .supply(supply_o), .pwr_dn(pwr_down_req_o),
        .status(status_o)
    );
endmodule

// File: rtl/card_irq_chk.sv
module card_irq_chk
    import card_irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input ev_set_t           ev,
    input logic              acc,
    input logic              irq_n,
    input logic [LVL_W-1:0]  supply,
    input logic              pwr_dn,
    input logic [STAT_W-1:0] status
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (irq_n && status == '0 && supply == '0 && !pwr_dn));

    a_r4_event_raises: assert property (@(posedge clk) disable iff (rst)
        (ev != '0) |=> !irq_n);

    a_r3_fault_zeroes_supply: assert property (@(posedge clk) disable iff (rst)
        (ev.ovl || ev.ext) |=> (supply == '0));

    a_r7_extract_pulse: assert property (@(posedge clk) disable iff (rst)
        ev.ext |=> pwr_dn);

    a_r6_clear_needs_cmd: assert property (@(posedge clk) disable iff (rst)
        (!irq_n && !acc) |=> !irq_n);

    a_r9_cs_high_frozen: assert property (@(posedge clk) disable iff (rst)
        (cs_n && ev == '0) |=> ($stable(supply) && $stable(irq_n) && $stable(status)));

    a_r11_event_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (ev != '0 && acc) |=> !irq_n);
endmodule

bind card_irq_ctrl card_irq_chk u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n_i), .ev(ev_w), .acc(acc_w),
    .irq_n(irq_n_o), .supply(supply_o), .pwr_dn(pwr_down_req_o),
    .status(status_o)
);

// File: tb/sim_card_irq_ctrl.sv
`timescale 1ns/1ps
module sim_card_irq_ctrl;
    localparam int STG = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       card_det = 1'b0;
    logic       ovl = 1'b0;
    logic       cs_n = 1'b1;
    logic       addr_hit = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       irq_n;
    logic [1:0] supply;
    logic       pwr_dn;
    logic [7:0] status;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit done = 0;

    always #2 clk = ~clk;

    card_irq_ctrl #(.SYNC_STAGES(STG)) u0 (
        .clk(clk), .rst(rst), .card_det_i(card_det), .ovl_i(ovl),
        .cs_n_i(cs_n), .addr_hit_i(addr_hit), .cmd_valid_i(cmd_valid),
        .cmd_byte_i(cmd_byte), .irq_n_o(irq_n), .supply_o(supply),
        .pwr_down_req_o(pwr_dn), .status_o(status)
    );

    // behavioural reference model
    logic [STG-1:0] m_det, m_ovl;
    logic m_dp, m_op, m_pend, m_pwr, m_last_ins;
    logic [2:0] m_cause;
    logic [1:0] m_sup;

    always @(posedge clk) begin
        automatic bit ins, ext, ov, acc, fits;
        started <= 1;
        if (rst) begin
            m_det <= '0; m_ovl <= '0; m_dp <= 0; m_op <= 0;
            m_pend <= 0; m_pwr <= 0; m_last_ins <= 0; m_cause <= 0; m_sup <= 0;
        end else begin
            ins = m_det[STG-1] && !m_dp;
            ext = !m_det[STG-1] && m_dp;
            ov  = m_ovl[STG-1] && !m_op;
            acc = cmd_valid && !cs_n && addr_hit &&
                  (cmd_byte[7] == 1'b0 || cmd_byte[7:5] == 3'b101);
            fits = m_last_ins ? (cmd_byte[1:0] != 0) : (cmd_byte[1:0] == 0);
            if (ins || ext || ov) begin
                m_pend <= 1;
                m_cause <= m_cause | {ov, ext, ins};
                m_last_ins <= !ov && !ext;
            end else if (acc && m_pend && fits) begin
                m_pend <= 0;
                m_cause <= 0;
                m_last_ins <= 0;
            end
            if (ov || ext) m_sup <= 0;
            else if (acc) m_sup <= cmd_byte[1:0];
            m_pwr <= ext;
            m_det <= {m_det[STG-2:0], card_det};
            m_ovl <= {m_ovl[STG-2:0], ovl};
            m_dp <= m_det[STG-1];
            m_op <= m_ovl[STG-1];
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (irq_n !== !m_pend || supply !== m_sup || pwr_dn !== m_pwr ||
                status !== {m_pend, 2'b00, m_sup, m_cause}) begin
                errors++;
                $display("FAIL R10 model t=%0t act irq_n=%b sup=%0d pwr=%b st=%h exp irq_n=%b sup=%0d pwr=%b st=%h",
                         $time, irq_n, supply, pwr_dn, status,
                         !m_pend, m_sup, m_pwr, {m_pend, 2'b00, m_sup, m_cause});
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input logic cs_low, input logic hit);
        cs_n = !cs_low; addr_hit = hit; cmd_valid = 1; cmd_byte = b;
        cyc(1);
        cs_n = 1; addr_hit = 0; cmd_valid = 0; cmd_byte = 8'h00;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        chk(irq_n == 1 && status == 8'h00 && supply == 0 && !pwr_dn, "R1 reset", status, 0);
        rst = 0;
        cyc(1);
        chk(irq_n == 1 && status == 8'h00, "R1 after reset", status, 0);

        // R2/R4 insertion with chip select high
        card_det = 1;
        cyc(STG);
        chk(irq_n == 1, "R2 latency early", irq_n, 1);
        cyc(1);
        chk(irq_n == 0 && status == 8'h81, "R2 R4 insertion", status, 8'h81);

        // R9 rejected commands
        send(8'h01, 1'b0, 1'b1);
        chk(irq_n == 0 && supply == 0 && status == 8'h81, "R9 cs high", status, 8'h81);
        send(8'h01, 1'b1, 1'b0);
        chk(irq_n == 0 && status == 8'h81, "R9 no addr", status, 8'h81);
        send(8'hC1, 1'b1, 1'b1);
        chk(irq_n == 0 && status == 8'h81, "R9 R5 opcode 110", status, 8'h81);

        // R6 wrong level keeps interrupt
        send(8'h00, 1'b1, 1'b1);
        chk(irq_n == 0 && supply == 0, "R6 mismatch", irq_n, 0);
        send(8'h01, 1'b1, 1'b1);
        chk(irq_n == 1 && status == 8'h08, "R6 R5 ack insertion", status, 8'h08);

        // R7 extraction
        card_det = 0;
        cyc(STG + 1);
        chk(irq_n == 0 && pwr_dn == 1 && supply == 0 && status == 8'h82, "R7 extraction", status, 8'h82);
        cyc(1);
        chk(pwr_dn == 0, "R7 single pulse", pwr_dn, 0);
        send(8'hA0, 1'b1, 1'b1);
        chk(irq_n == 1 && status == 8'h00, "R6 R5 ack 101 class", status, 0);

        // insertion, ack with level 2
        card_det = 1;
        cyc(STG + 1);
        send(8'h42, 1'b1, 1'b1);
        chk(irq_n == 1 && supply == 2 && status == 8'h10, "R5 level load", status, 8'h10);

        // R3 overload
        ovl = 1;
        cyc(STG + 1);
        chk(irq_n == 0 && supply == 0 && status == 8'h84, "R3 overload", status, 8'h84);
        send(8'h00, 1'b1, 1'b1);
        chk(irq_n == 1, "R3 R6 ack overload", irq_n, 1);
        ovl = 0;
        cyc(STG + 2);

        // R8 remove and reinsert
        card_det = 0;
        cyc(STG + 1);
        card_det = 1;
        for (int k = 0; k < STG + 3; k++) begin
            chk(irq_n == 0, "R8 no glitch", irq_n, 0);
            cyc(1);
        end
        chk(status[1:0] == 2'b11, "R8 both causes", status[1:0], 3);
        send(8'h00, 1'b1, 1'b1);
        chk(irq_n == 0, "R8 R6 zero ack rejected", irq_n, 0);
        send(8'h03, 1'b1, 1'b1);
        chk(irq_n == 1 && supply == 3, "R8 ack reinsertion", supply, 3);

        // R11 event and matching clear in the same cycle
        card_det = 0;
        cyc(STG);
        send(8'h00, 1'b1, 1'b1);
        chk(irq_n == 0 && status[1] == 1, "R11 event wins", status, 8'h82);
        send(8'h00, 1'b1, 1'b1);
        chk(irq_n == 1, "R11 later clear", irq_n, 1);

        // R12 overload and insertion together
        ovl = 1; card_det = 1;
        cyc(STG + 1);
        chk(status == 8'h85, "R12 both causes", status, 8'h85);
        send(8'h01, 1'b1, 1'b1);
        chk(irq_n == 0, "R12 nonzero rejected", irq_n, 0);
        send(8'h00, 1'b1, 1'b1);
        chk(irq_n == 1, "R12 zero accepted", irq_n, 1);

        cyc(2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule